// File: doc/BRIEF.md
# Glitch-Free Divide-by-2/4/8 Clock Generator

This block derives three clocks at one half, one quarter and one eighth of an input clock. The three outputs are the bits of one 3-bit counter clocked by a single internal clock, so every edge the outputs share occurs on the same input edge. The counter counts down, so all three outputs rise together each time it wraps.

A common enable starts and stops all three outputs together. The enable is captured on the falling edge of the input clock and gates the internal clock. The gated clock can therefore only switch on or off while it is already low, and no truncated pulse ever reaches the counter.

An asynchronous master reset forces every stage low at once. Its release passes through a short falling-edge pipeline, so the enable flop and the counter leave reset together. Driving several instances from one reset brings them into exact phase.

Top module: `clk_div248`

## Requirements
- R1: `div2_o`, `div4_o` and `div8_o` are bits 0, 1 and 2 of a counter that steps down by one on every enabled rising input edge. The sequence is 000, 111, 110, ... 001, 000. This gives ratios of 2, 4 and 8 with a 50% duty cycle.
- R2: When the counter wraps from 000, all three outputs rise on the same input edge. With enable held high, this happens once every 8 input cycles.
- R3: `enable` is sampled on the falling edge of `clk_in`. A change made after a falling edge has no effect on the rising edge that follows it; it acts from the next rising edge onward.
- R4: While the sampled enable is low, all three outputs keep their levels and the counter does not advance.
- R5: When enable returns, counting resumes from the held value. No period is shortened or restarted.
- R6: While `mrst` is high, all three outputs are low. Asserting `mrst` clears them at once, without waiting for a clock edge.
- R7: Suppose `mrst` is released while the clock is high and `enable` is high. The first output change then comes on the rising edge that follows the third falling edge after release. On that edge all three outputs go high.
- R8: Outputs change only at rising edges of `clk_in`, whatever the timing of `enable`. The sampled enable changes only while `clk_in` is low.
- R9: Two instances given a common `mrst` and the same `enable` after release produce identical outputs, whatever their earlier histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| enable | input | 1 | Common run/stop control, sampled on the falling edge |
| mrst | input | 1 | Master reset, active high, asynchronous assert |
| div2_o | output | 1 | Input clock divided by 2 |
| div4_o | output | 1 | Input clock divided by 4 |
| div8_o | output | 1 | Input clock divided by 8 |

## Verification
Two things can fall on the same falling edge: the capture of a new enable value and the last stage of the reset release. The bench releases reset with enable already high and requires exactly two quiet rising edges before all outputs jump to 111. An enable change can also coincide with a counter wrap; random enable patterns over hundreds of cycles make both coincidences occur many times. Each sample is judged against a bench counter model, and a second instance with a different history must match once both share a reset.

// File: rtl/clk_div248.sv
module clk_div248 #(
  parameter int RST_SYNC = 2,
  parameter int CNT_W    = 3
) (
  input  logic clk_in,
  input  logic enable,
  input  logic mrst,
  output logic div2_o,
  output logic div4_o,
  output logic div8_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_i;
  logic                en_q;
  logic                gclk;
  logic [CNT_W-1:0]    cnt;

  always_ff @(negedge clk_in or posedge mrst)
    if (mrst) rst_pipe <= '1;
    else      rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b0};

  assign rst_i = rst_pipe[RST_SYNC-1];

  always_ff @(negedge clk_in or posedge rst_i)
    if (rst_i) en_q <= 1'b0;
    else       en_q <= enable;

  assign gclk = clk_in & en_q;

  always_ff @(posedge gclk or posedge rst_i)
    if (rst_i) cnt <= '0;
    else       cnt <= cnt - ONE;

  assign div2_o = cnt[0];
  assign div4_o = cnt[1];
  assign div8_o = cnt[2];

  AST_DIV2_TOGGLE: assert property (@(posedge clk_in) disable iff (rst_i)
    en_q |=> div2_o != $past(div2_o)) else $error("div2 did not toggle"); // R1

  AST_DIV4_BORROW: assert property (@(posedge clk_in) disable iff (rst_i)
    en_q && !div2_o |=> div4_o != $past(div4_o)) else $error("div4 step"); // R1

  AST_DIV8_BORROW: assert property (@(posedge clk_in) disable iff (rst_i)
    en_q && !div2_o && !div4_o |=> div8_o != $past(div8_o)) else $error("div8 step"); // R2

  AST_HOLD_STOPPED: assert property (@(posedge clk_in) disable iff (rst_i)
    !en_q |=> $stable({div8_o, div4_o, div2_o})) else $error("moved while stopped"); // R4

  AST_RESET_LOW: assert property (@(posedge clk_in)
    mrst |-> {div8_o, div4_o, div2_o} == 3'b000) else $error("outputs not cleared"); // R6

  always @(en_q)
    if (!rst_i) AST_EN_CHANGE_LOW: assert (!clk_in) else $error("enable moved while clock high"); // R8

endmodule

// File: tb/test_clk_div248.sv
module test_clk_div248;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic enable, enable_b, mrst;
  logic d2, d4, d8, d2b, d4b, d8b;
  logic [2:0] outs, outs_b;
  logic [2:0] mcnt;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit b_sync = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_div248 i_clk_div248 (.clk_in(clk), .enable(enable), .mrst(mrst),
                           .div2_o(d2), .div4_o(d4), .div8_o(d8));
  clk_div248 i_clk_div248_b (.clk_in(clk), .enable(enable_b), .mrst(mrst),
                             .div2_o(d2b), .div4_o(d4b), .div8_o(d8b));

  assign outs   = {d8, d4, d2};
  assign outs_b = {d8b, d4b, d2b};

  function automatic logic [2:0] next_cnt(input logic [2:0] c, input bit e);
    return e ? c - 3'd1 : c;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_both(input string tag);
    check(tag, outs, mcnt);
    if (b_sync) check("R9", outs_b, mcnt);
  endtask

  // called at posedge+2; the enable set here is captured at the next falling edge
  task automatic step(input bit e, input string tag);
    enable = e;
    enable_b = b_sync ? e : 1'($urandom_range(0, 1));
    #4;
    check_both("R8");
    @(posedge clk); #2;
    mcnt = next_cnt(mcnt, e);
    check_both(tag);
  endtask

  task automatic release_rst();
    enable = 1'b1;
    enable_b = 1'b1;
    mrst = 1'b0;
    repeat (2) begin
      @(posedge clk); #2;
      mcnt = 3'b000;
      check_both("R7");
    end
    @(posedge clk); #2;
    mcnt = 3'b111;
    check_both("R7");
  endtask

  initial begin
    void'($urandom(32'd4242));
    mrst = 1'b1;
    enable = 1'b1;
    enable_b = 1'b0;
    mcnt = 3'b000;
    repeat (3) @(posedge clk);
    #2;
    check("R6", outs, 3'b000);
    release_rst();

    for (int i = 0; i < 16; i++) step(1'b1, (mcnt == 3'b000) ? "R2" : "R1");
    for (int i = 0; i < 5; i++) step(1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b1, "R5");

    // r3_late_drop: low pulse after the falling edge is not seen
    enable = 1'b1;
    #4 enable = 1'b0;
    @(posedge clk); #2;
    mcnt = next_cnt(mcnt, 1'b1);
    check("R3", outs, mcnt);
    step(1'b0, "R3");
    // r3_late_rise: high after the falling edge does not run the next edge
    #4 enable = 1'b1;
    @(posedge clk); #2;
    check("R3", outs, mcnt);
    step(1'b1, "R3");

    begin
      bit prev_e = 1'b1;
      for (int i = 0; i < 300; i++) begin
        bit e = ($urandom_range(0, 3) != 0);
        step(e, e ? (prev_e ? ((mcnt == 3'b000) ? "R2" : "R1") : "R5") : "R4");
        prev_e = e;
      end
    end

    // R6: asynchronous clear while the clock is high, then common realignment
    mrst = 1'b1;
    #1;
    check("R6", outs, 3'b000);
    check("R6", outs_b, 3'b000);
    @(posedge clk); #2;
    b_sync = 1'b1;
    release_rst();
    for (int i = 0; i < 200; i++) step(($urandom_range(0, 4) != 0), "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule